// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year, with a century bit that flips each time the year rolls over. It counts a reference strobe, nominally 32,768 pulses per second, and divides it down internally. Every full division advances the chain by one second, and carries ripple through the fields in the same clock cycle.

The hours field supports either a 24-hour or a 12-hour format. The format is chosen by a flag stored inside the hours value itself. A host writes or reads any field through a small register port. A write takes effect on the next clock edge and restarts the sub-second divider. A halt input freezes the chain. A one-cycle tick output marks every completed second so that neighbouring comparison logic (for example, alarms) can sample settled values.

Top module: `cal_chain`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in BCD. Each wraps from 0x59 to 0x00 and carries to the next field on that wrap.
- R2: Hours live at address 2. With bit 6 clear (24-hour), bits 5:0 count 0x00 to 0x23, and 0x23 wraps to 0x00 with a day carry. An advance never changes the format bit.
- R3: With bit 6 set (12-hour), bit 5 is the PM flag and bits 4:0 hold 0x01 to 0x12. 0x51 (11 AM) goes to 0x72 (12 PM). 0x71 (11 PM) goes to 0x52 (12 AM) and produces a day carry. 0x52 goes to 0x41 and 0x72 goes to 0x61.
- R4: Day of week (address 3, bits 2:0) advances on each day carry, counting 1 to 7 and then returning to 1.
- R5: Date (address 4, bits 5:0) advances on each day carry. The last date is 31 in months 1, 3, 5, 7, 8, 10 and 12, and 30 in months 4, 6, 9 and 11. In February it is 29 when the year's value is a multiple of 4 (00 included) and 28 otherwise. After the last date, the date returns to 01 and the month advances.
- R6: Month (address 5, bits 4:0) counts 1 to 12, then returns to 1 and advances the year. Year (address 6, all bits) counts 0x00 to 0x99. Month bit 7 is the century bit and toggles when the year wraps from 0x99 to 0x00.
- R7: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R8: Bits outside each field read 0 whatever was written: sec/min bit 7, hours bit 7, day-of-week bits 7:3, date bits 7:6, month bits 6:5. Address 7 reads 0x00, and a write to it changes nothing.
- R9: While halt is high the sub-second divider and all fields hold and no tick is produced. Host writes are still accepted.
- R10: A host write to addresses 0 to 6 replaces the field on the next edge, suppresses any advance in that cycle and restarts the divider. The next advance therefore needs another REF_DIV reference strobes.
- R11: The chain advances once per REF_DIV accepted reference strobes. The tick output is high for exactly the one cycle in which the advanced values first appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference strobe, one pulse per reference period |
| halt | input | 1 | High freezes divider and counters |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Field address for a write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Field address for a read |
| rd_data | output | 8 | Read data, combinational from the stored fields |
| sec_tick | output | 1 | One-cycle pulse when an advanced second becomes visible |

## Verification
On every cycle the embedded assertions check several local rules. A wrapping seconds or minutes field lands on zero. An advance keeps the hour format bit. The 11 PM step lands on 12 AM, and day 7 steps to day 1. The century bit flips on the year wrap, and an advanced date is never zero. The divider and the fields stay still while halted, and a write is never followed by a tick. The tick never lasts two cycles, and the unused bits read zero. Only the bench scenarios can show the month-length and leap-year table, the full carry ripple from seconds to century, the exact strobe count between a write and the next tick, and agreement of every read field with a behavioural calendar under sparse reference patterns.

// File: rtl/cal_pkg.sv
package cal_pkg;

   typedef enum logic [2:0] {
      FLD_SEC   = 3'd0,
      FLD_MIN   = 3'd1,
      FLD_HOUR  = 3'd2,
      FLD_WDAY  = 3'd3,
      FLD_DATE  = 3'd4,
      FLD_MONTH = 3'd5,
      FLD_YEAR  = 3'd6,
      FLD_NONE  = 3'd7
   } field_e;

   // BCD increment of a two-digit value (no range limit applied here)
   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // last valid date of a month, in BCD; leap when 10*t+o is a multiple of 4,
   // which equals 2*t+o modulo 4
   function automatic logic [5:0] month_limit(input logic [4:0] mon, input logic [7:0] yr);
      logic [4:0] s;
      s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
      case (mon)
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         5'h02:                      return (s[1:0] == 2'b00) ? 6'h29 : 6'h28;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_subsec.sv
module cal_subsec #(
   parameter int REF_DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_en,
   input  logic run,
   input  logic clear,
   output logic adv
);
   localparam int  PH_W    = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
   localparam bit  IS_POW2 = ((REF_DIV & (REF_DIV - 1)) == 0);

   initial begin
      assert (REF_DIV >= 2) else $error("cal_subsec: REF_DIV must be at least 2");
   end

   logic [PH_W-1:0] phase;
   logic            at_end;

   generate
      if (IS_POW2) begin : g_pow2
         assign at_end = &phase;
      end else begin : g_cmp
         assign at_end = (phase == PH_W'(REF_DIV - 1));
      end
   endgenerate

   assign adv = ref_en && run && !clear && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                phase <= '0;
      else if (clear)            phase <= '0;
      else if (ref_en && run)    phase <= at_end ? '0 : phase + 1'b1;
   end

   assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(phase));

   assert_phase_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (phase == '0));

endmodule

// File: rtl/cal_sexa.sv
module cal_sexa (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       load,
   input  logic [6:0] load_val,
   output logic [6:0] value,
   output logic       wrap
);
   localparam logic [6:0] LAST = 7'h59;

   logic [7:0] nxt;

   always_comb nxt = cal_pkg::bcd_next({1'b0, value});

   assign wrap = step && (value >= LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (load) value <= load_val;
      else if (step) value <= wrap ? 7'h00 : nxt[6:0];
   end

   assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !load) |=> (value == 7'h00));

   assert_stay_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && value <= LAST) |=> (value <= LAST));

endmodule

// File: rtl/cal_hour.sv
module cal_hour (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       load,
   input  logic [6:0] load_val,
   output logic [6:0] value,
   output logic       day_carry
);
   logic [6:0] nxt;
   logic       carry;
   logic [7:0] inc12;
   logic [7:0] inc24;

   always_comb begin
      inc12 = cal_pkg::bcd_next({3'b000, value[4:0]});
      inc24 = cal_pkg::bcd_next({2'b00, value[5:0]});
      nxt   = value;
      carry = 1'b0;
      if (value[6]) begin
         if (value[4:0] >= 5'h12) begin
            nxt = {1'b1, value[5], 5'h01};
         end else if (value[4:0] == 5'h11) begin
            nxt   = {1'b1, ~value[5], 5'h12};
            carry = value[5];
         end else begin
            nxt = {1'b1, value[5], inc12[4:0]};
         end
      end else begin
         if (value[5:0] >= 6'h23) begin
            nxt   = 7'h00;
            carry = 1'b1;
         end else begin
            nxt = {1'b0, inc24[5:0]};
         end
      end
   end

   assign day_carry = step && carry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (load) value <= load_val;
      else if (step) value <= nxt;
   end

   assert_format_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (value[6] == $past(value[6])));

   assert_midnight_12h_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && value == 7'h71) |=> (value == 7'h52));

endmodule

// File: rtl/cal_calendar.sv
module cal_calendar (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic                 load,
   input  cal_pkg::field_e      load_sel,
   input  logic [7:0]           load_val,
   output logic [2:0]           wday,
   output logic [5:0]           date,
   output logic [4:0]           month,
   output logic                 century,
   output logic [7:0]           year
);
   import cal_pkg::*;

   logic [5:0] limit;
   logic       date_wrap, month_wrap, year_wrap;
   logic [7:0] date_inc, month_inc, year_inc;

   always_comb begin
      limit      = month_limit(month, year);
      date_wrap  = (date >= limit);
      month_wrap = (month >= 5'h12);
      year_wrap  = (year >= 8'h99);
      date_inc   = bcd_next({2'b00, date});
      month_inc  = bcd_next({3'b000, month});
      year_inc   = bcd_next(year);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wday    <= 3'd1;
         date    <= 6'h01;
         month   <= 5'h01;
         century <= 1'b0;
         year    <= 8'h00;
      end else if (load) begin
         case (load_sel)
            FLD_WDAY:  wday  <= load_val[2:0];
            FLD_DATE:  date  <= load_val[5:0];
            FLD_MONTH: begin
               century <= load_val[7];
               month   <= load_val[4:0];
            end
            FLD_YEAR:  year  <= load_val;
            default: ;
         endcase
      end else if (step) begin
         wday <= (wday >= 3'd7) ? 3'd1 : wday + 3'd1;
         if (date_wrap) begin
            date <= 6'h01;
            if (month_wrap) begin
               month <= 5'h01;
               year  <= year_wrap ? 8'h00 : year_inc;
               if (year_wrap) century <= ~century;
            end else begin
               month <= month_inc[4:0];
            end
         end else begin
            date <= date_inc[5:0];
         end
      end
   end

   assert_wday_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && wday == 3'd7) |=> (wday == 3'd1));

   assert_date_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (date != 6'h00));

   assert_century_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && date_wrap && month_wrap && year_wrap) |=> (century != $past(century)));

endmodule

// File: rtl/cal_chain.sv
module cal_chain #(
   parameter int REF_DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic       halt,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       sec_tick
);
   import cal_pkg::*;

   logic       wr_hit, adv;
   logic       ld_sec, ld_min, ld_hour, ld_cal;
   logic [6:0] sec_q, min_q, hour_q;
   logic       sec_wrap, min_wrap, day_carry;
   logic [2:0] wday_q;
   logic [5:0] date_q;
   logic [4:0] month_q;
   logic       century_q;
   logic [7:0] year_q;

   assign wr_hit  = wr_en && (wr_addr != FLD_NONE);
   assign ld_sec  = wr_en && (wr_addr == FLD_SEC);
   assign ld_min  = wr_en && (wr_addr == FLD_MIN);
   assign ld_hour = wr_en && (wr_addr == FLD_HOUR);
   assign ld_cal  = wr_en && (wr_addr >= FLD_WDAY) && (wr_addr != FLD_NONE);

   cal_subsec #(.REF_DIV(REF_DIV)) u_subsec (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .run(!halt),
      .clear(wr_hit), .adv(adv)
   );

   cal_sexa u_sec (
      .clk(clk), .rst_n(rst_n), .step(adv), .load(ld_sec),
      .load_val(wr_data[6:0]), .value(sec_q), .wrap(sec_wrap)
   );

   cal_sexa u_min (
      .clk(clk), .rst_n(rst_n), .step(sec_wrap), .load(ld_min),
      .load_val(wr_data[6:0]), .value(min_q), .wrap(min_wrap)
   );

   cal_hour u_hour (
      .clk(clk), .rst_n(rst_n), .step(min_wrap), .load(ld_hour),
      .load_val(wr_data[6:0]), .value(hour_q), .day_carry(day_carry)
   );

   cal_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .step(day_carry), .load(ld_cal),
      .load_sel(field_e'(wr_addr)), .load_val(wr_data),
      .wday(wday_q), .date(date_q), .month(month_q),
      .century(century_q), .year(year_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_tick <= 1'b0;
      else        sec_tick <= adv;
   end

   always_comb begin
      case (field_e'(rd_addr))
         FLD_SEC:   rd_data = {1'b0, sec_q};
         FLD_MIN:   rd_data = {1'b0, min_q};
         FLD_HOUR:  rd_data = {1'b0, hour_q};
         FLD_WDAY:  rd_data = {5'b00000, wday_q};
         FLD_DATE:  rd_data = {2'b00, date_q};
         FLD_MONTH: rd_data = {century_q, 2'b00, month_q};
         FLD_YEAR:  rd_data = year_q;
         default:   rd_data = 8'h00;
      endcase
   end

   assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   assert_write_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> !sec_tick);

   assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)
                            && $stable(date_q) && !sec_tick));

   assert_spare_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == FLD_NONE) |-> (rd_data == 8'h00));

endmodule

// File: tb/test_cal_chain.sv
module test_cal_chain;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int WATCHDOG   = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b0, halt = 1'b0, wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0, rd_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       sec_tick;

   int n_checks = 0;
   int n_fails  = 0;
   string scen = "R7";

   always #(CLK_PERIOD/2) clk = ~clk;

   cal_chain #(.REF_DIV(DIV)) i_cal_chain (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .halt(halt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick)
   );

   // behavioural calendar model in plain integers
   int m_sec, m_min, m_h24, m_fmt12, m_wday, m_date, m_mon, m_year, m_cent, m_phase, m_tick;

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(logic [7:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic int days_in(int mon, int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] exp_read(int a);
      int h;
      case (a)
         0: return to_bcd(m_sec);
         1: return to_bcd(m_min);
         2: begin
            if (m_fmt12 != 0) begin
               h = m_h24 % 12;
               if (h == 0) h = 12;
               return 8'h40 | ((m_h24 >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
            end
            return to_bcd(m_h24);
         end
         3: return 8'(m_wday);
         4: return to_bcd(m_date);
         5: return ((m_cent != 0) ? 8'h80 : 8'h00) | to_bcd(m_mon);
         6: return to_bcd(m_year);
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_advance();
      m_sec++;
      if (m_sec < 60) return;
      m_sec = 0; m_min++;
      if (m_min < 60) return;
      m_min = 0; m_h24++;
      if (m_h24 < 24) return;
      m_h24 = 0;
      m_wday = (m_wday == 7) ? 1 : m_wday + 1;
      m_date++;
      if (m_date <= days_in(m_mon, m_year)) return;
      m_date = 1; m_mon++;
      if (m_mon <= 12) return;
      m_mon = 1; m_year++;
      if (m_year <= 99) return;
      m_year = 0; m_cent = 1 - m_cent;
   endtask

   task automatic model_write(int a, logic [7:0] d);
      int h12;
      case (a)
         0: m_sec = from_bcd(d & 8'h7F);
         1: m_min = from_bcd(d & 8'h7F);
         2: begin
            m_fmt12 = d[6];
            if (d[6]) begin
               h12 = from_bcd(d & 8'h1F);
               m_h24 = ((h12 == 12) ? 0 : h12) + (d[5] ? 12 : 0);
            end else m_h24 = from_bcd(d & 8'h3F);
         end
         3: m_wday = int'(d[2:0]);
         4: m_date = from_bcd(d & 8'h3F);
         5: begin m_cent = d[7]; m_mon = from_bcd(d & 8'h1F); end
         6: m_year = from_bcd(d);
         default: ;
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_min = 0; m_h24 = 0; m_fmt12 = 0; m_wday = 1; m_date = 1;
         m_mon = 1; m_year = 0; m_cent = 0; m_phase = 0; m_tick = 0;
      end else begin
         m_tick = 0;
         if (wr_en && wr_addr != 3'd7) begin
            model_write(int'(wr_addr), wr_data);
            m_phase = 0;
         end else if (ref_en && !halt) begin
            if (m_phase == DIV - 1) begin
               m_phase = 0; model_advance(); m_tick = 1;
            end else m_phase++;
         end
      end
   end

   function automatic string addr_tag(int a);
      case (a)
         0, 1: return "R1";
         2: return (m_fmt12 != 0) ? "R3" : "R2";
         3: return "R4";
         4: return "R5";
         5, 6: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      if (!rst_n) return;
      check({addr_tag(int'(rd_addr)), "/", scen, " field read"}, rd_data, exp_read(int'(rd_addr)));
      check({"R11/", scen, " tick"}, {7'd0, sec_tick}, 8'(m_tick));
   endtask

   task automatic step(logic r, logic h, logic w, logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      compare_all();
      ref_en = r; halt = h; wr_en = w; wr_addr = a; wr_data = d;
      rd_addr = rd_addr + 3'd1;
   endtask

   task automatic run(int n, int period);
      for (int i = 0; i < n; i++) step((i % period) == 0, 1'b0, 1'b0, 3'd0, 8'h00);
   endtask

   task automatic put(logic [2:0] a, logic [7:0] d);
      step(1'b1, 1'b0, 1'b1, a, d);
   endtask

   task automatic set_all(logic [7:0] hh, logic [7:0] mm, logic [7:0] ss,
                          logic [7:0] wd, logic [7:0] dd, logic [7:0] mo, logic [7:0] yy);
      put(3'd6, yy); put(3'd5, mo); put(3'd4, dd); put(3'd3, wd);
      put(3'd2, hh); put(3'd1, mm); put(3'd0, ss);
   endtask

   task automatic read_now(logic [2:0] a, string tag, logic [7:0] exp);
      @(negedge clk);
      ref_en = 1'b0; wr_en = 1'b0; rd_addr = a;
      #1 check(tag, rd_data, exp);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int cnt;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R7 reset values
      read_now(3'd0, "R7 seconds", 8'h00);
      read_now(3'd1, "R7 minutes", 8'h00);
      read_now(3'd2, "R7 hours", 8'h00);
      read_now(3'd3, "R7 weekday", 8'h01);
      read_now(3'd4, "R7 date", 8'h01);
      read_now(3'd5, "R7 month", 8'h01);
      read_now(3'd6, "R7 year", 8'h00);
      run(40, 1);

      scen = "R6";
      set_all(8'h23, 8'h59, 8'h50, 8'h07, 8'h31, 8'h12, 8'h99);
      run(80, 1);
      read_now(3'd5, "R6 century set after year wrap", 8'h81);
      read_now(3'd6, "R6 year wrapped", 8'h00);
      read_now(3'd3, "R4 weekday wrapped", 8'h01);

      scen = "R5";
      set_all(8'h23, 8'h59, 8'h58, 8'h02, 8'h28, 8'h02, 8'h23);
      run(16, 1);
      read_now(3'd4, "R5 non-leap Feb end", 8'h01);
      set_all(8'h23, 8'h59, 8'h58, 8'h02, 8'h28, 8'h02, 8'h24);
      run(16, 1);
      read_now(3'd4, "R5 leap Feb 29", 8'h29);
      set_all(8'h23, 8'h59, 8'h58, 8'h02, 8'h28, 8'h02, 8'h00);
      run(16, 1);
      read_now(3'd4, "R5 year 00 leap", 8'h29);
      set_all(8'h23, 8'h59, 8'h57, 8'h05, 8'h30, 8'h04, 8'h31);
      run(20, 1);
      read_now(3'd5, "R5 April end to May", 8'h05);

      scen = "R3";
      set_all(8'h51, 8'h59, 8'h55, 8'h03, 8'h10, 8'h06, 8'h42);
      run(30, 1);
      read_now(3'd2, "R3 11AM to 12PM", 8'h72);
      set_all(8'h71, 8'h59, 8'h55, 8'h03, 8'h30, 8'h09, 8'h42);
      run(30, 1);
      read_now(3'd2, "R3 11PM to 12AM", 8'h52);
      read_now(3'd4, "R3 day carry at midnight", 8'h01);
      set_all(8'h52, 8'h59, 8'h57, 8'h03, 8'h10, 8'h06, 8'h42);
      run(20, 1);
      read_now(3'd2, "R3 12AM to 1AM", 8'h41);
      set_all(8'h72, 8'h59, 8'h57, 8'h03, 8'h10, 8'h06, 8'h42);
      run(20, 1);
      read_now(3'd2, "R3 12PM to 1PM", 8'h61);

      scen = "R8";
      put(3'd0, 8'hD9);
      read_now(3'd0, "R8 seconds bit7 masked", 8'h59);
      put(3'd4, 8'hC5);
      read_now(3'd4, "R8 date bits 7:6 masked", 8'h05);
      put(3'd3, 8'hFE);
      read_now(3'd3, "R8 weekday upper bits masked", 8'h06);
      put(3'd5, 8'hE9);
      read_now(3'd5, "R8 month bits 6:5 masked", 8'h89);
      put(3'd7, 8'h33);
      read_now(3'd7, "R8 spare address reads zero", 8'h00);
      read_now(3'd5, "R8 spare write no effect", 8'h89);

      scen = "R9";
      for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, 3'd0, 8'h00);
      step(1'b1, 1'b1, 1'b1, 3'd1, 8'h17);
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, 3'd0, 8'h00);
      read_now(3'd1, "R9 write during halt", 8'h17);
      run(40, 2);

      scen = "R10";
      put(3'd0, 8'h10);
      cnt = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         compare_all();
         ref_en = 1'b1; wr_en = 1'b0; halt = 1'b0; rd_addr = rd_addr + 3'd1;
         cnt++;
         if (sec_tick) break;
      end
      check("R10 cycles from write to tick", 8'(cnt), 8'd5);
      for (int i = 0; i < 60; i++) step(1'b1, 1'b0, (i % 7) == 3, 3'd0, 8'h20);

      scen = "R11";
      set_all(8'h00, 8'h58, 8'h30, 8'h04, 8'h15, 8'h08, 8'h77);
      run(600, 3);
      run(600, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule